// File: doc/BRIEF.md
# I2C Bus Clear and Start Sequencer

This block returns a single-controller I2C bus to a known idle state before a new transfer, and then issues the start condition for that transfer. When a request arrives, it stops driving both lines and waits for the clock line to read back high. While a target device is still holding the data line low, the block drives the clock low and then releases it, once per attempt. Each of these clock pulses lets the target shift out the remainder of a transfer it was interrupted in. When both lines read high, the block pulls the data line low while the clock stays released, which is a start condition. It then reports completion.

The block has no byte shifter. A separate transfer engine takes over after the start condition. Until then the sequencer holds both lines low, and it lets go of them when the request is withdrawn. The length of every clock phase comes from a configuration input and is counted in system clocks. A clock line that never rises, and a data line that stays low after the pulse budget is used up, are reported on separate one-cycle failure outputs. Line inputs are expected to be already synchronous to `clk`.

Top module: `i2c_bus_clear`

## Requirements
- R1: During and right after reset, both drive-low enables are 0 and all three status outputs are 0.
- R2: When `recover_req` is 1 while the block is idle, the block leaves idle on that edge. It latches `half_cycles` and releases both lines (`scl_drive_low`=0, `sda_drive_low`=0).
- R3: After the release, the block waits until `scl_in` reads 1. It then keeps both lines released for one phase (the latched `half_cycles` clocks) and samples the lines at the last clock of that phase.
- R4: If the sample finds `scl_in`=1 and `sda_in`=0 and fewer than MAX_PULSES pulses have been issued, the block drives `scl_drive_low`=1 for exactly one phase and then returns to the wait of R3.
- R5: If that sample finds `sda_in`=0 after MAX_PULSES (default 9) pulses, the block pulses `fail_sda_stuck` for one cycle and returns to idle with both lines released. No more than MAX_PULSES clock pulses are ever issued per request.
- R6: If the sample finds both lines at 1, the block drives `sda_drive_low`=1 with `scl_drive_low`=0 for one phase. It then pulses `done` and holds both enables at 1 until `recover_req` is 0, when it releases both and goes idle.
- R7: If `scl_in` stays 0 for SCL_TIMEOUT consecutive clocks during the wait of R3, the block pulses `fail_scl_stuck` for one cycle and returns to idle with both lines released.
- R8: `done`, `fail_sda_stuck` and `fail_scl_stuck` are each at most one cycle wide, and no two of them are 1 in the same cycle.
- R9: A latched `half_cycles` value of 0 gives a phase of one clock.
- R10: Changes on `half_cycles` after a sequence has started have no effect on that sequence's phase lengths.
- R11: If `scl_in` reads 0 at the sample point of R3 (the clock is being held low from outside), the block returns to the wait of R3 without counting a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| recover_req | input | 1 | Starts a clear-and-start sequence from idle; 0 ends the hand-over hold |
| half_cycles | input | HALF_W | Phase length in clocks, latched at request; 0 means 1 |
| scl_in | input | 1 | Clock line level read back from the pad |
| sda_in | input | 1 | Data line level read back from the pad |
| scl_drive_low | output | 1 | 1 pulls the clock line low (open drain) |
| sda_drive_low | output | 1 | 1 pulls the data line low (open drain) |
| done | output | 1 | One-cycle pulse after the start condition has been issued |
| fail_sda_stuck | output | 1 | One-cycle pulse when the data line stays low after the pulse budget |
| fail_scl_stuck | output | 1 | One-cycle pulse when the clock line does not rise in time |

## Verification
The bench builds the block with HALF_W=4, SCL_TIMEOUT=40 and the default pulse budget of 9. The short timeout makes the clock-stuck failure reachable within a few dozen cycles. The narrow phase field lets a phase of 0, 1 and mid-range lengths be tried. With these values, a target that needs exactly nine pulses (which still succeeds) and one that needs ten (which fails) each finish within a few hundred cycles. A modelled target that stretches the clock during the release phase exercises the re-wait path.

// File: rtl/i2c_bus_clear_pkg.sv
package i2c_bus_clear_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_HI = 3'd1,
    ST_HIGH    = 3'd2,
    ST_LOW     = 3'd3,
    ST_START   = 3'd4,
    ST_HOLD    = 3'd5
  } clr_state_e;

endpackage

// File: rtl/i2cr_phase_timer.sv
module i2cr_phase_timer #(
  parameter int HALF_W      = 8,
  parameter int SCL_TIMEOUT = 1000,
  parameter int TW          = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_len,
  input  logic [HALF_W-1:0] len_in,
  output logic              phase_end,
  output logic              tmo_hit
);

  logic [TW-1:0]     cnt_q;
  logic [TW-1:0]     cnt_d;
  logic [HALF_W-1:0] len_q;
  logic [HALF_W-1:0] len_eff;
  logic [TW-1:0]     last_idx;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + TW'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (load_len) begin
      len_q <= len_in;
    end
  end

  assign len_eff   = (len_q == '0) ? HALF_W'(1) : len_q;
  assign last_idx  = {{(TW-HALF_W){1'b0}}, len_eff} - TW'(1);
  assign phase_end = (cnt_q == last_idx);
  assign tmo_hit   = (cnt_q == TW'(SCL_TIMEOUT - 1));

endmodule

// File: rtl/i2cr_attempt_ctr.sv
module i2cr_attempt_ctr #(
  parameter int MAX_PULSES = 9,
  parameter int AW         = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);

  logic [AW-1:0] tries_q;
  logic [AW-1:0] tries_d;

  always_comb begin
    tries_d = tries_q;
    if (clr) begin
      tries_d = '0;
    end else if (inc && !at_limit) begin
      tries_d = tries_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
    end else begin
      tries_q <= tries_d;
    end
  end

  assign at_limit = (tries_q == AW'(MAX_PULSES));

endmodule

// File: rtl/i2cr_ctrl_fsm.sv
module i2cr_ctrl_fsm
  import i2c_bus_clear_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic scl_in,
  input  logic sda_in,
  input  logic phase_end,
  input  logic tmo_hit,
  input  logic at_limit,
  output logic tmr_clr,
  output logic len_load,
  output logic try_clr,
  output logic try_inc,
  output logic scl_low,
  output logic sda_low,
  output logic done_o,
  output logic fail_sda_o,
  output logic fail_scl_o
);

  clr_state_e state_q, state_d;
  logic done_d, fail_sda_d, fail_scl_d;

  always_comb begin
    state_d    = state_q;
    len_load   = 1'b0;
    try_clr    = 1'b0;
    try_inc    = 1'b0;
    done_d     = 1'b0;
    fail_sda_d = 1'b0;
    fail_scl_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d  = ST_WAIT_HI;
          len_load = 1'b1;
          try_clr  = 1'b1;
        end
      end
      ST_WAIT_HI: begin
        if (scl_in) begin
          state_d = ST_HIGH;
        end else if (tmo_hit) begin
          state_d    = ST_IDLE;
          fail_scl_d = 1'b1;
        end
      end
      ST_HIGH: begin
        if (phase_end) begin
          if (!scl_in) begin
            state_d = ST_WAIT_HI;
          end else if (sda_in) begin
            state_d = ST_START;
          end else if (at_limit) begin
            state_d    = ST_IDLE;
            fail_sda_d = 1'b1;
          end else begin
            state_d = ST_LOW;
            try_inc = 1'b1;
          end
        end
      end
      ST_LOW: begin
        if (phase_end) begin
          state_d = ST_WAIT_HI;
        end
      end
      ST_START: begin
        if (phase_end) begin
          state_d = ST_HOLD;
          done_d  = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!req) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q) || (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      done_o     <= 1'b0;
      fail_sda_o <= 1'b0;
      fail_scl_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      done_o     <= done_d;
      fail_sda_o <= fail_sda_d;
      fail_scl_o <= fail_scl_d;
    end
  end

  assign scl_low = (state_q == ST_LOW) || (state_q == ST_HOLD);
  assign sda_low = (state_q == ST_START) || (state_q == ST_HOLD);

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int HALF_W      = 8,
  parameter int SCL_TIMEOUT = 1000,
  parameter int MAX_PULSES  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recover_req,
  input  logic [HALF_W-1:0] half_cycles,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              done,
  output logic              fail_sda_stuck,
  output logic              fail_scl_stuck
);

  localparam int TO_W = $clog2(SCL_TIMEOUT + 1);
  localparam int TW   = ((HALF_W > TO_W) ? HALF_W : TO_W) + 1;
  localparam int AW   = $clog2(MAX_PULSES + 1) + 1;

  logic tmr_clr, len_load, phase_end, tmo_hit;
  logic try_clr, try_inc, at_limit;

  i2cr_phase_timer #(
    .HALF_W     (HALF_W),
    .SCL_TIMEOUT(SCL_TIMEOUT),
    .TW         (TW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .load_len (len_load),
    .len_in   (half_cycles),
    .phase_end(phase_end),
    .tmo_hit  (tmo_hit)
  );

  i2cr_attempt_ctr #(
    .MAX_PULSES(MAX_PULSES),
    .AW        (AW)
  ) u_tries (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (try_clr),
    .inc     (try_inc),
    .at_limit(at_limit)
  );

  i2cr_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (recover_req),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .phase_end (phase_end),
    .tmo_hit   (tmo_hit),
    .at_limit  (at_limit),
    .tmr_clr   (tmr_clr),
    .len_load  (len_load),
    .try_clr   (try_clr),
    .try_inc   (try_inc),
    .scl_low   (scl_drive_low),
    .sda_low   (sda_drive_low),
    .done_o    (done),
    .fail_sda_o(fail_sda_stuck),
    .fail_scl_o(fail_scl_stuck)
  );

endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_in,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic done,
  input logic fail_sda_stuck,
  input logic fail_scl_stuck
);

  int unsigned pulse_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_seen <= 0;
    end else if (done || fail_sda_stuck || fail_scl_stuck) begin
      pulse_seen <= 0;
    end else if (scl_drive_low && !sda_drive_low && !$past(scl_drive_low)) begin
      pulse_seen <= pulse_seen + 1;
    end
  end

  assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail_sda_stuck, fail_scl_stuck}));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fail_sda_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_sda_stuck |=> !fail_sda_stuck);

  assert_start_on_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> (!scl_drive_low && $past(scl_in) && $past(sda_in)));

  assert_done_holds_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_drive_low && sda_drive_low));

  assert_sda_fail_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_sda_stuck |-> (!scl_drive_low && !sda_drive_low && !$past(sda_in)));

  assert_pulse_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_seen <= MAX_PULSES);

  assert_scl_fail_line_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_scl_stuck |-> (!$past(scl_in) && !scl_drive_low && !sda_drive_low));

endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_in        (scl_in),
  .sda_in        (sda_in),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .done          (done),
  .fail_sda_stuck(fail_sda_stuck),
  .fail_scl_stuck(fail_scl_stuck)
);

// File: tb/i2c_bus_clear_bench.sv
`timescale 1ns/1ps
module i2c_bus_clear_bench;

  localparam int HW  = 4;
  localparam int TO  = 40;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [HW-1:0] cfg = '0;
  logic scl_hold = 1'b0;
  int   stk = 0;
  logic scl_prev = 1'b1;

  logic scl_oe, sda_oe, done, f_sda, f_scl;
  wire  scl_line = !scl_oe && !scl_hold;
  wire  sda_line = !sda_oe && (stk == 0);

  always #2.5 clk = ~clk;

  i2c_bus_clear #(.HALF_W(HW), .SCL_TIMEOUT(TO), .MAX_PULSES(MAXP)) u_i2c_bus_clear (
    .clk(clk), .rst_n(rst_n), .recover_req(req), .half_cycles(cfg),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_drive_low(scl_oe), .sda_drive_low(sda_oe),
    .done(done), .fail_sda_stuck(f_sda), .fail_scl_stuck(f_scl)
  );

  int checks = 0;
  int bad = 0;
  bit fin = 1'b0;
  int cyc = 0;

  // stuck target: releases data line one step per clock low phase it sees
  always @(posedge clk) begin
    scl_prev <= scl_line;
    if (scl_prev && !scl_line && stk > 0) stk <= stk - 1;
  end

  // behavioural reference: phase 0 idle,1 wait,2 release,3 low,4 start,5 hold
  int mph, mcnt, mtries, mlen;
  bit m_done, m_fs, m_fc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph = 0; mcnt = 0; mtries = 0; mlen = 1;
      m_done = 0; m_fs = 0; m_fc = 0;
    end else begin
      m_done = 0; m_fs = 0; m_fc = 0;
      case (mph)
        0: if (req) begin mph = 1; mcnt = 0; mtries = 0; mlen = (cfg == 0) ? 1 : int'(cfg); end
        1: if (scl_line) begin mph = 2; mcnt = 0; end
           else if (mcnt == TO - 1) begin mph = 0; m_fc = 1; end
           else mcnt++;
        2: if (mcnt == mlen - 1) begin
             mcnt = 0;
             if (!scl_line) mph = 1;
             else if (sda_line) mph = 4;
             else if (mtries == MAXP) begin mph = 0; m_fs = 1; end
             else begin mph = 3; mtries++; end
           end else mcnt++;
        3: if (mcnt == mlen - 1) begin mph = 1; mcnt = 0; end else mcnt++;
        4: if (mcnt == mlen - 1) begin mph = 5; mcnt = 0; m_done = 1; end else mcnt++;
        default: if (!req) mph = 0;
      endcase
    end
  end

  // per-cycle comparison (R4 clock enable, R6 data enable/done, R5, R7)
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit e_scl, e_sda;
      e_scl = (mph == 3) || (mph == 5);
      e_sda = (mph == 4) || (mph == 5);
      checks++;
      if (scl_oe !== e_scl || sda_oe !== e_sda || done !== m_done ||
          f_sda !== m_fs || f_scl !== m_fc) begin
        bad++;
        if (scl_oe !== e_scl) $display("FAIL R4 scl_drive_low act=%b exp=%b t=%0t", scl_oe, e_scl, $time);
        if (sda_oe !== e_sda) $display("FAIL R6 sda_drive_low act=%b exp=%b t=%0t", sda_oe, e_sda, $time);
        if (done !== m_done)  $display("FAIL R6 done act=%b exp=%b t=%0t", done, m_done, $time);
        if (f_sda !== m_fs)   $display("FAIL R5 fail_sda_stuck act=%b exp=%b t=%0t", f_sda, m_fs, $time);
        if (f_scl !== m_fc)   $display("FAIL R7 fail_scl_stuck act=%b exp=%b t=%0t", f_scl, m_fc, $time);
      end
    end
  end

  // clock pulse measurement at the pins
  int run = 0, npulse = 0, lastw = 0;
  always @(negedge clk) begin
    if (scl_oe && !sda_oe) run++;
    else if (run > 0) begin npulse++; lastw = run; run = 0; end
  end

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp_v);
    end
  endtask

  // outcome: 1 done, 2 sda fail, 3 scl fail, 0 none
  task automatic run_seq(input int half, input int stuck, output int outcome);
    outcome = 0;
    npulse = 0; lastw = 0;
    @(negedge clk);
    cfg = half[HW-1:0];
    stk = stuck;
    req = 1'b1;
    for (int i = 0; i < 3000 && outcome == 0; i++) begin
      @(negedge clk);
      if (done) outcome = 1;
      else if (f_sda) outcome = 2;
      else if (f_scl) outcome = 3;
    end
    req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  int oc;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe/status during reset", {scl_oe, sda_oe, done, f_sda, f_scl}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe/status after reset", {scl_oe, sda_oe, done, f_sda, f_scl}, 0);

    // R2 R6 clean bus
    run_seq(3, 0, oc);
    chk("R6 clean bus outcome", oc, 1);
    chk("R2 clean bus pulses", npulse, 0);
    chk("R6 lines released after req drop", {scl_oe, sda_oe}, 0);

    // R3 R4 three pulses needed
    run_seq(3, 3, oc);
    chk("R4 stuck3 outcome", oc, 1);
    chk("R4 stuck3 pulse count", npulse, 3);
    chk("R3 stuck3 phase width", lastw, 3);

    // R5 exactly at budget
    run_seq(1, 9, oc);
    chk("R5 stuck9 outcome", oc, 1);
    chk("R5 stuck9 pulse count", npulse, 9);

    // R5 one beyond budget
    run_seq(1, 10, oc);
    chk("R5 stuck10 outcome", oc, 2);
    chk("R5 stuck10 pulse count", npulse, 9);
    chk("R5 lines released after fail", {scl_oe, sda_oe}, 0);
    stk = 0;

    // R7 clock held low
    scl_hold = 1'b1;
    run_seq(2, 0, oc);
    chk("R7 scl held outcome", oc, 3);
    chk("R7 no pulses issued", npulse, 0);
    scl_hold = 1'b0;
    repeat (2) @(negedge clk);

    // R9 zero phase length
    run_seq(0, 2, oc);
    chk("R9 zero half outcome", oc, 1);
    chk("R9 zero half width", lastw, 1);

    // R10 configuration changed mid-sequence
    npulse = 0; lastw = 0;
    cfg = 4'd4; stk = 2; req = 1'b1;
    @(negedge clk);
    cfg = 4'd1;
    oc = 0;
    for (int i = 0; i < 3000 && oc == 0; i++) begin
      @(negedge clk);
      if (done) oc = 1; else if (f_sda || f_scl) oc = 2;
    end
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 outcome", oc, 1);
    chk("R10 width kept at latched value", lastw, 4);

    // R11 clock stretched during release phase
    npulse = 0;
    cfg = 4'd5; stk = 0; req = 1'b1;
    for (int i = 0; i < 200 && !scl_line; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    scl_hold = 1'b1;
    repeat (6) @(negedge clk);
    scl_hold = 1'b0;
    oc = 0;
    for (int i = 0; i < 3000 && oc == 0; i++) begin
      @(negedge clk);
      if (done) oc = 1; else if (f_sda || f_scl) oc = 2;
    end
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 stretch outcome", oc, 1);
    chk("R11 no pulse counted", npulse, 0);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      fin = 1'b1;
      checks++;
      bad++;
      $display("FAIL watchdog act=%0d exp<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule